// File: doc/BRIEF.md
# Address Qualifier and Fault Router

This block sits at the front of a two-stage address translator. Each request carries a 64-bit effective address, a hypervisor flag, a relocation flag and an access kind. The block checks that the address is well formed. It then uses the two most significant address bits, called the quadrant, to choose which partition identifier and which process identifier the later table walk will use. Some quadrants are not allowed for a guest.

When the hypervisor runs with relocation off, no tables are used. The block forms the real address itself and grants every permission. The page-table walk and the permission checks live elsewhere. That logic reports its storage faults back through a separate input so that this block builds every fault record.

Any fault is captured in one registered record. The record holds the interrupt kind, the captured data address, a data status word and an error code. It stays until it is acknowledged. While the record is held, no new work is accepted.

Top module: `addr_qual_router`

## Requirements
- R1: After reset, `res_valid` and `flt_pending` are 0, `flt_kind` is 0 (none), and `flt_dar`, `flt_dsr` and `flt_err` are 0.
- R2: Outside hypervisor real mode, a request whose reserved field `req_ea[61:52]` is nonzero raises a segment fault and produces no result. This field is the run below the quadrant bits.
- R3: With `req_hv`=1 and `req_reloc`=1, the quadrant `req_ea[63:62]` selects the (partition, process) pair as follows:
  - 0 gives (0, `pid_reg`)
  - 1 gives (`lpid_reg`, `pid_reg`)
  - 2 gives (`lpid_reg`, 0)
  - 3 gives (0, 0)
- R4: With `req_hv`=0 (whatever `req_reloc` is):
  - quadrant 0 gives (`lpid_reg`, `pid_reg`)
  - quadrant 3 gives (`lpid_reg`, 0)
  - quadrants 1 and 2 raise a segment fault
- R5: Access kind encoding is 0 fetch, 1 load, 2 store, and 3 is handled as a load.
  - A segment fault on a fetch records `flt_kind`=1 (instruction segment) with `flt_dar`, `flt_dsr` and `flt_err` all 0.
  - On a load or store it records `flt_kind`=2 (data segment), with `flt_dar` = the effective address and `flt_dsr` = `flt_err` = 0.
- R6: With `req_hv`=1 and `req_reloc`=0, the result has the following fields:
  - `res_bypass`=1 and `res_prot`=3'b111 (read, write, execute)
  - both identifiers 0
  - `res_raddr` = the effective address with its top 4 bits cleared, ORed with `rmo_reg` only when `req_ea[63]` is 0
  - no reserved-field or quadrant check applies.
- R7: A result is a one-cycle `res_valid` pulse in the cycle after the accepted request. A qualified (non-bypass) result has `res_bypass`=0, `res_raddr`=0 and `res_prot`=0.
- R8: A storage fault report (`rpt_valid`) records a fault in the cycle after the report.
  - A fetch report gives `flt_kind`=3 (instruction storage) with `flt_err`=`rpt_cause` and `flt_dar`=`flt_dsr`=0.
  - A load report gives `flt_kind`=4 (data storage) with `flt_dsr`=`rpt_cause`, `flt_dar`=`rpt_ea` and `flt_err`=0.
  - A store report is the same as a load report, except that `flt_dsr` also has bit 25 (is-store) set.
- R9: A fault record stays unchanged until `flt_ack`. The cycle after `flt_ack`, the record returns to the R1 values. Requests and reports that arrive while a fault is pending are dropped, including in the acknowledge cycle.
- R10: When a report and a request arrive in the same idle cycle, the report is recorded and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_ea | input | 64 | Effective address |
| req_hv | input | 1 | Hypervisor mode |
| req_reloc | input | 1 | Relocation enable |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| lpid_reg | input | 12 | Current partition identifier |
| pid_reg | input | 20 | Current process identifier |
| rmo_reg | input | 64 | Real-mode offset |
| rpt_valid | input | 1 | Storage fault report strobe |
| rpt_ea | input | 64 | Faulting effective address of the report |
| rpt_acc | input | 2 | Access kind of the report |
| rpt_cause | input | 32 | Cause word of the report |
| flt_ack | input | 1 | Fault acknowledge |
| res_valid | output | 1 | Result pulse |
| res_bypass | output | 1 | Result is a real-mode address |
| res_lpid | output | 12 | Selected partition identifier |
| res_pid | output | 20 | Selected process identifier |
| res_raddr | output | 64 | Real address (bypass only) |
| res_prot | output | 3 | Granted rights {exec, write, read} |
| flt_pending | output | 1 | Fault record held |
| flt_kind | output | 3 | 0 none, 1 inst segment, 2 data segment, 3 inst storage, 4 data storage |
| flt_dar | output | 64 | Captured data address |
| flt_dsr | output | 32 | Data fault status word |
| flt_err | output | 32 | Instruction fault error code |

## Verification
Random requests cover all four quadrants in both privilege modes, with relocation on and off, over all access kinds. In one request out of eight the reserved field is filled, which separates reserved-field faults from quadrant-legality faults. Real-mode addresses are drawn with the top bit both set and clear, and with nonzero top nibbles, which shows whether the offset merge and the nibble clearing happen on the right condition. Storage reports of each access kind check where the cause is routed and whether the is-store bit is added. Directed sequences issue requests during a pending fault, in the acknowledge cycle, and at the same time as a report, to expose any leak of dropped work.

// File: rtl/aq_pkg.sv
package aq_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FK_NONE  = 3'd0,
        FK_ISEG  = 3'd1,
        FK_DSEG  = 3'd2,
        FK_ISTO  = 3'd3,
        FK_DSTO  = 3'd4
    } fkind_e;

endpackage

// File: rtl/aq_quadrant_map.sv
module aq_quadrant_map #(
    parameter int LPID_W   = 12,
    parameter int PID_W    = 20,
    parameter int RSV_BITS = 10
) (
    input  logic [RSV_BITS+1:0] ea_top,
    input  logic                hv,
    input  logic [LPID_W-1:0]   lpid_reg,
    input  logic [PID_W-1:0]    pid_reg,
    output logic [LPID_W-1:0]   lpid,
    output logic [PID_W-1:0]    pid,
    output logic                seg_fault
);
    localparam int TOP_W = RSV_BITS + 2;

    logic [1:0] quad;
    logic       rsv_bad;

    assign quad    = ea_top[TOP_W-1 -: 2];
    assign rsv_bad = |ea_top[RSV_BITS-1:0];

    always_comb begin
        lpid      = '0;
        pid       = '0;
        seg_fault = rsv_bad;
        if (hv) begin
            unique case (quad)
                2'd0: pid = pid_reg;
                2'd1: begin lpid = lpid_reg; pid = pid_reg; end
                2'd2: lpid = lpid_reg;
                default: ;
            endcase
        end else begin
            unique case (quad)
                2'd0: begin lpid = lpid_reg; pid = pid_reg; end
                2'd3: lpid = lpid_reg;
                default: seg_fault = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/aq_realmode.sv
module aq_realmode #(
    parameter int EA_W     = 64,
    parameter int CLR_BITS = 4
) (
    input  logic [EA_W-1:0] ea,
    input  logic [EA_W-1:0] rmo,
    output logic [EA_W-1:0] raddr
);
    localparam int KEEP_W = EA_W - CLR_BITS;

    logic [EA_W-1:0] base;

    assign base  = {{CLR_BITS{1'b0}}, ea[KEEP_W-1:0]};
    assign raddr = ea[EA_W-1] ? base : (base | rmo);
endmodule

// File: rtl/aq_fault_form.sv
module aq_fault_form
    import aq_pkg::*;
#(
    parameter int EA_W      = 64,
    parameter int CAUSE_W   = 32,
    parameter int STORE_BIT = 25
) (
    input  logic               is_seg,
    input  logic [1:0]         acc,
    input  logic [EA_W-1:0]    ea,
    input  logic [CAUSE_W-1:0] cause,
    output fkind_e             kind,
    output logic [EA_W-1:0]    dar,
    output logic [CAUSE_W-1:0] dsr,
    output logic [CAUSE_W-1:0] err
);
    localparam logic [CAUSE_W-1:0] STORE_MASK = CAUSE_W'(1) << STORE_BIT;

    logic fetch;
    assign fetch = (acc == ACC_FETCH);

    always_comb begin
        dar = '0;
        dsr = '0;
        err = '0;
        if (is_seg) begin
            kind = fetch ? FK_ISEG : FK_DSEG;
            if (!fetch) dar = ea;
        end else if (fetch) begin
            kind = FK_ISTO;
            err  = cause;
        end else begin
            kind = FK_DSTO;
            dar  = ea;
            dsr  = (acc == ACC_STORE) ? (cause | STORE_MASK) : cause;
        end
    end
endmodule

// File: rtl/addr_qual_router.sv
module addr_qual_router
    import aq_pkg::*;
#(
    parameter int EA_W      = 64,
    parameter int LPID_W    = 12,
    parameter int PID_W     = 20,
    parameter int CAUSE_W   = 32,
    parameter int STORE_BIT = 25,
    parameter int RSV_BITS  = 10,
    parameter int CLR_BITS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [EA_W-1:0]    req_ea,
    input  logic               req_hv,
    input  logic               req_reloc,
    input  logic [1:0]         req_acc,
    input  logic [LPID_W-1:0]  lpid_reg,
    input  logic [PID_W-1:0]   pid_reg,
    input  logic [EA_W-1:0]    rmo_reg,
    input  logic               rpt_valid,
    input  logic [EA_W-1:0]    rpt_ea,
    input  logic [1:0]         rpt_acc,
    input  logic [CAUSE_W-1:0] rpt_cause,
    input  logic               flt_ack,
    output logic               res_valid,
    output logic               res_bypass,
    output logic [LPID_W-1:0]  res_lpid,
    output logic [PID_W-1:0]   res_pid,
    output logic [EA_W-1:0]    res_raddr,
    output logic [2:0]         res_prot,
    output logic               flt_pending,
    output logic [2:0]         flt_kind,
    output logic [EA_W-1:0]    flt_dar,
    output logic [CAUSE_W-1:0] flt_dsr,
    output logic [CAUSE_W-1:0] flt_err
);
    localparam int TOP_W = RSV_BITS + 2;
    localparam logic [2:0] PROT_ALL = 3'b111;

    typedef struct packed {
        logic               res_valid;
        logic               res_bypass;
        logic [LPID_W-1:0]  res_lpid;
        logic [PID_W-1:0]   res_pid;
        logic [EA_W-1:0]    res_raddr;
        logic [2:0]         res_prot;
        logic               flt_pending;
        fkind_e             flt_kind;
        logic [EA_W-1:0]    flt_dar;
        logic [CAUSE_W-1:0] flt_dsr;
        logic [CAUSE_W-1:0] flt_err;
    } state_t;

    state_t st_d, st_q;

    logic [LPID_W-1:0]  qm_lpid;
    logic [PID_W-1:0]   qm_pid;
    logic               qm_fault;
    logic [EA_W-1:0]    rm_raddr;
    fkind_e             sg_kind, so_kind;
    logic [EA_W-1:0]    sg_dar, so_dar;
    logic [CAUSE_W-1:0] sg_dsr, so_dsr, sg_err, so_err;
    logic               bypass;

    assign bypass = req_hv && !req_reloc;

    aq_quadrant_map #(.LPID_W(LPID_W), .PID_W(PID_W), .RSV_BITS(RSV_BITS)) u_qmap (
        .ea_top   (req_ea[EA_W-1 -: TOP_W]),
        .hv       (req_hv),
        .lpid_reg (lpid_reg),
        .pid_reg  (pid_reg),
        .lpid     (qm_lpid),
        .pid      (qm_pid),
        .seg_fault(qm_fault)
    );

    aq_realmode #(.EA_W(EA_W), .CLR_BITS(CLR_BITS)) u_real (
        .ea   (req_ea),
        .rmo  (rmo_reg),
        .raddr(rm_raddr)
    );

    aq_fault_form #(.EA_W(EA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) u_seg_form (
        .is_seg(1'b1),
        .acc   (req_acc),
        .ea    (req_ea),
        .cause ('0),
        .kind  (sg_kind),
        .dar   (sg_dar),
        .dsr   (sg_dsr),
        .err   (sg_err)
    );

    aq_fault_form #(.EA_W(EA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)) u_sto_form (
        .is_seg(1'b0),
        .acc   (rpt_acc),
        .ea    (rpt_ea),
        .cause (rpt_cause),
        .kind  (so_kind),
        .dar   (so_dar),
        .dsr   (so_dsr),
        .err   (so_err)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        if (st_q.flt_pending) begin
            if (flt_ack) begin
                st_d.flt_pending = 1'b0;
                st_d.flt_kind    = FK_NONE;
                st_d.flt_dar     = '0;
                st_d.flt_dsr     = '0;
                st_d.flt_err     = '0;
            end
        end else if (rpt_valid) begin
            st_d.flt_pending = 1'b1;
            st_d.flt_kind    = so_kind;
            st_d.flt_dar     = so_dar;
            st_d.flt_dsr     = so_dsr;
            st_d.flt_err     = so_err;
        end else if (req_valid) begin
            if (bypass) begin
                st_d.res_valid  = 1'b1;
                st_d.res_bypass = 1'b1;
                st_d.res_lpid   = '0;
                st_d.res_pid    = '0;
                st_d.res_raddr  = rm_raddr;
                st_d.res_prot   = PROT_ALL;
            end else if (qm_fault) begin
                st_d.flt_pending = 1'b1;
                st_d.flt_kind    = sg_kind;
                st_d.flt_dar     = sg_dar;
                st_d.flt_dsr     = sg_dsr;
                st_d.flt_err     = sg_err;
            end else begin
                st_d.res_valid  = 1'b1;
                st_d.res_bypass = 1'b0;
                st_d.res_lpid   = qm_lpid;
                st_d.res_pid    = qm_pid;
                st_d.res_raddr  = '0;
                st_d.res_prot   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.flt_kind <= FK_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid   = st_q.res_valid;
    assign res_bypass  = st_q.res_bypass;
    assign res_lpid    = st_q.res_lpid;
    assign res_pid     = st_q.res_pid;
    assign res_raddr   = st_q.res_raddr;
    assign res_prot    = st_q.res_prot;
    assign flt_pending = st_q.flt_pending;
    assign flt_kind    = st_q.flt_kind;
    assign flt_dar     = st_q.flt_dar;
    assign flt_dsr     = st_q.flt_dsr;
    assign flt_err     = st_q.flt_err;
endmodule

// File: rtl/aq_checker.sv
module aq_checker #(
    parameter int EA_W    = 64,
    parameter int LPID_W  = 12,
    parameter int PID_W   = 20,
    parameter int CAUSE_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_hv,
    input logic               req_reloc,
    input logic               rpt_valid,
    input logic               flt_ack,
    input logic               res_valid,
    input logic               res_bypass,
    input logic [LPID_W-1:0]  res_lpid,
    input logic [PID_W-1:0]   res_pid,
    input logic [2:0]         res_prot,
    input logic               flt_pending,
    input logic [2:0]         flt_kind,
    input logic [EA_W-1:0]    flt_dar,
    input logic [CAUSE_W-1:0] flt_err
);
    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_pending && !flt_ack |=> flt_pending && $stable(flt_kind) && $stable(flt_dar));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_pending |=> !res_valid);

    // R6
    bypass_rwx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_bypass |-> res_prot == 3'b111 && res_lpid == '0 && res_pid == '0);

    // R6
    bypass_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_pending && !rpt_valid && req_valid && req_hv && !req_reloc |=> res_valid && res_bypass);

    // R7
    qual_noprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_bypass |-> res_prot == 3'b000);

    // R10
    rpt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_pending && rpt_valid |=> flt_pending && !res_valid);

    // R1
    idle_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_pending |-> flt_kind == 3'd0);

    // R5
    iseg_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_pending && flt_kind == 3'd1 |-> flt_dar == '0 && flt_err == '0);
endmodule

bind addr_qual_router aq_checker #(
    .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .CAUSE_W(CAUSE_W)
) u_aq_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hv(req_hv),
    .req_reloc(req_reloc), .rpt_valid(rpt_valid), .flt_ack(flt_ack),
    .res_valid(res_valid), .res_bypass(res_bypass), .res_lpid(res_lpid),
    .res_pid(res_pid), .res_prot(res_prot), .flt_pending(flt_pending),
    .flt_kind(flt_kind), .flt_dar(flt_dar), .flt_err(flt_err)
);

// File: tb/addr_qual_router_test.sv
`timescale 1ns/1ps
module addr_qual_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_ea = '0;
    logic        req_hv = 1'b0;
    logic        req_reloc = 1'b0;
    logic [1:0]  req_acc = '0;
    logic [11:0] lpid_reg = 12'h5A3;
    logic [19:0] pid_reg = 20'hC0DE1;
    logic [63:0] rmo_reg = 64'h0000_0040_0000_0000;
    logic        rpt_valid = 1'b0;
    logic [63:0] rpt_ea = '0;
    logic [1:0]  rpt_acc = '0;
    logic [31:0] rpt_cause = '0;
    logic        flt_ack = 1'b0;
    logic        res_valid, res_bypass, flt_pending;
    logic [11:0] res_lpid;
    logic [19:0] res_pid;
    logic [63:0] res_raddr, flt_dar;
    logic [2:0]  res_prot, flt_kind;
    logic [31:0] flt_dsr, flt_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addr_qual_router uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
        .req_hv(req_hv), .req_reloc(req_reloc), .req_acc(req_acc),
        .lpid_reg(lpid_reg), .pid_reg(pid_reg), .rmo_reg(rmo_reg),
        .rpt_valid(rpt_valid), .rpt_ea(rpt_ea), .rpt_acc(rpt_acc),
        .rpt_cause(rpt_cause), .flt_ack(flt_ack), .res_valid(res_valid),
        .res_bypass(res_bypass), .res_lpid(res_lpid), .res_pid(res_pid),
        .res_raddr(res_raddr), .res_prot(res_prot), .flt_pending(flt_pending),
        .flt_kind(flt_kind), .flt_dar(flt_dar), .flt_dsr(flt_dsr), .flt_err(flt_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_real(input logic [63:0] ea, input logic [63:0] rmo);
        logic [63:0] r;
        r = ea & 64'h0FFF_FFFF_FFFF_FFFF;
        if (!ea[63]) r = r | rmo;
        return r;
    endfunction

    // returns {illegal, lpid, pid}
    function automatic logic [32:0] exp_ids(input logic [63:0] ea, input logic hv);
        logic [1:0] q;
        logic bad;
        logic [11:0] l;
        logic [19:0] p;
        q = ea[63:62];
        bad = (ea[61:52] != 10'd0);
        l = '0;
        p = '0;
        if (hv) begin
            if (q == 2'd0) p = pid_reg;
            if (q == 2'd1) begin l = lpid_reg; p = pid_reg; end
            if (q == 2'd2) l = lpid_reg;
        end else begin
            if (q == 2'd1 || q == 2'd2) bad = 1'b1;
            if (q == 2'd0) begin l = lpid_reg; p = pid_reg; end
            if (q == 2'd3) l = lpid_reg;
        end
        return {bad, l, p};
    endfunction

    task automatic do_ack();
        @(negedge clk);
        flt_ack = 1'b1;
        @(negedge clk);
        flt_ack = 1'b0;
        chk("R9 cleared after ack", {flt_pending, flt_kind}, 64'd0);
        chk("R9 record zeroed", flt_dar | {32'd0, flt_dsr | flt_err}, 64'd0);
    endtask

    task automatic do_req(input logic [63:0] ea, input logic hv, input logic reloc,
                          input logic [1:0] acc);
        logic [32:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_hv = hv; req_reloc = reloc; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        if (hv && !reloc) begin
            chk("R6 real result valid", {res_valid, res_bypass, flt_pending}, {61'd0, 3'b110});
            chk("R6 real address", res_raddr, exp_real(ea, rmo_reg));
            chk("R6 real ids/prot", {res_lpid, res_pid, res_prot}, {32'd0, 3'b111});
        end else begin
            e = exp_ids(ea, hv);
            if (e[32]) begin
                chk(ea[61:52] != 0 ? "R2 reserved fault" : "R4 guest quadrant fault",
                    {res_valid, flt_pending}, 64'd1);
                chk("R5 segment kind", flt_kind, (acc == 2'd0) ? 64'd1 : 64'd2);
                chk("R5 segment dar", flt_dar, (acc == 2'd0) ? 64'd0 : ea);
                chk("R5 segment dsr/err", {flt_dsr, flt_err}, 64'd0);
                do_ack();
            end else begin
                chk("R7 qualified pulse", {res_valid, res_bypass, flt_pending}, {61'd0, 3'b100});
                chk(hv ? "R3 hv ids" : "R4 guest ids", {res_lpid, res_pid}, {32'd0, e[31:0]});
                chk("R7 qualified raddr/prot", res_raddr | {61'd0, res_prot}, 64'd0);
                @(negedge clk);
                chk("R7 single pulse", res_valid, 64'd0);
            end
        end
    endtask

    task automatic do_rpt(input logic [63:0] ea, input logic [1:0] acc, input logic [31:0] cause);
        logic [31:0] d;
        @(negedge clk);
        rpt_valid = 1'b1; rpt_ea = ea; rpt_acc = acc; rpt_cause = cause;
        @(negedge clk);
        rpt_valid = 1'b0;
        d = (acc == 2'd2) ? (cause | 32'h0200_0000) : cause;
        chk("R8 report pending", flt_pending, 64'd1);
        if (acc == 2'd0) begin
            chk("R8 inst storage kind", flt_kind, 64'd3);
            chk("R8 inst storage fields", {flt_err, flt_dsr}, {cause, 32'd0});
            chk("R8 inst storage dar", flt_dar, 64'd0);
        end else begin
            chk("R8 data storage kind", flt_kind, 64'd4);
            chk("R8 data storage fields", {flt_dsr, flt_err}, {d, 32'd0});
            chk("R8 data storage dar", flt_dar, ea);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset flags", {res_valid, flt_pending, flt_kind}, 64'd0);
        chk("R1 reset record", flt_dar | {32'd0, flt_dsr | flt_err}, 64'd0);
        rst_n = 1'b1;

        // directed corner cases
        do_req(64'hF000_0000_0000_1234, 1'b1, 1'b0, 2'd1); // R6 top bit set: no offset
        do_req(64'h7123_4567_89AB_CDEF, 1'b1, 1'b0, 2'd0); // R6 top clear: offset merged
        do_req(64'h7FF0_0000_0000_0000, 1'b1, 1'b0, 2'd2); // R6 reserved bits ignored
        do_req(64'h0010_0000_0000_0000, 1'b1, 1'b1, 2'd0); // R2 fetch
        do_req(64'hC000_0000_0000_0040, 1'b1, 1'b1, 2'd1); // R3 q3
        do_req(64'h4000_0000_0000_0040, 1'b0, 1'b1, 2'd2); // R4 q1 illegal
        do_req(64'h8000_0000_0000_0040, 1'b0, 1'b0, 2'd0); // R4 q2 illegal fetch
        do_rpt(64'h1234_0000_0000_0010, 2'd0, 32'h4000_0000); // R8 fetch
        do_ack();
        do_rpt(64'h2234_0000_0000_0020, 2'd1, 32'h0800_0000); // R8 load
        do_ack();
        do_rpt(64'h3234_0000_0000_0030, 2'd2, 32'h0800_0000); // R8 store
        // R9 ignored while pending
        @(negedge clk);
        req_valid = 1'b1; req_ea = 64'h0; req_hv = 1'b1; req_reloc = 1'b0;
        rpt_valid = 1'b1; rpt_acc = 2'd0; rpt_cause = 32'hFFFF_FFFF;
        @(negedge clk);
        rpt_valid = 1'b0;
        chk("R9 request dropped while pending", res_valid, 64'd0);
        chk("R9 record unchanged", {flt_kind, flt_dsr}, {29'd0, 3'd4, 32'h0A00_0000});
        flt_ack = 1'b1;
        @(negedge clk);
        flt_ack = 1'b0; req_valid = 1'b0;
        chk("R9 request in ack cycle dropped", {res_valid, flt_pending}, 64'd0);
        // R10 report beats request
        @(negedge clk);
        req_valid = 1'b1; req_ea = 64'h0; req_hv = 1'b1; req_reloc = 1'b0;
        rpt_valid = 1'b1; rpt_ea = 64'h55; rpt_acc = 2'd1; rpt_cause = 32'h10;
        @(negedge clk);
        req_valid = 1'b0; rpt_valid = 1'b0;
        chk("R10 report wins", {res_valid, flt_pending, flt_kind}, {60'd0, 1'b0, 1'b1, 3'd4});
        do_ack();
        chk("R10 dropped request not replayed", res_valid, 64'd0);

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [63:0] ea;
            logic [1:0] acc;
            ea = {$urandom, $urandom};
            if ($urandom_range(7) != 0) ea[61:52] = '0;
            acc = 2'($urandom_range(2));
            lpid_reg = 12'($urandom);
            pid_reg  = 20'($urandom);
            rmo_reg  = {4'h0, 28'($urandom), 32'h0};
            if ($urandom_range(9) == 0) begin
                do_rpt(ea, acc, $urandom);
                do_ack();
            end else begin
                do_req(ea, 1'($urandom), 1'($urandom), acc);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule